// File: doc/BRIEF.md
# Floating-Point Calculator Instruction Sequencer

This block is the control path of a small register-based calculator that works on single-precision IEEE 754 values. It keeps a program counter and reads 16-bit words from an external program memory. It decodes each instruction and holds eight 32-bit working registers. For arithmetic it hands two operands to an external floating-point unit, pulses that unit's start line for the chosen operation and waits for the done reply. It then stores the result. A move instruction instead carries a 32-bit constant in the two words that follow it, and that constant is stored directly.

The stages do not overlap. Each one begins when the previous one reports completion, so one instruction finishes before the next is fetched. A word of all zeros stops the program. An exception reported by the arithmetic unit, or a malformed instruction word, parks the sequencer in an error state with a blinking indicator, and only reset leaves that state. While the sequencer is stopped, either way, a debug port reads back any working register.

Instruction layout: bits [15:12] opcode, [11:9] destination, [8:6] first source, [5:3] second source, [2:0] reserved (must be zero). Opcodes: 0 halt, 1 add, 2 subtract, 3 multiply, 4 divide, 5 move. Any other opcode is malformed.

Top module: `fpcalc_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the memory address is 0, no start line is high, and the halted, error and indicator outputs are 0. Every working register reads back as zero until it is written.
- R2: A fetch reads the word at the program counter. An arithmetic instruction advances the counter by 1. A move (opcode 5, bits [8:0] zero) reads its constant high half at address+1 and low half at address+2, and the next instruction is fetched at address+3.
- R3: In the fourth cycle after an arithmetic fetch, exactly one start line is high for exactly one cycle: add for opcode 1, subtract for 2, multiply for 3, divide for 4. At that time the operand outputs carry the registers named in bits [8:6] and [5:3].
- R4: The sequencer waits any number of cycles for done. The next fetch takes place four cycles after the cycle in which done is high.
- R5: The arithmetic result is written to the register named in bits [11:9]. A move writes {high half, low half} to its destination, and its next fetch comes six cycles after its own fetch.
- R6: An all-zero word sets halted from the next cycle on. After that there are no further starts, and the memory address stays where it is.
- R7: An exception that arrives with done sets the error output from the next cycle on. The result is not written, no further instructions run, and only reset clears the error.
- R8: A word with opcode 6 to 15, a nonzero reserved field, or opcode 0 with any nonzero bit sets the error output from the next cycle on, and no start follows.
- R9: In the error state the indicator begins at 0 and toggles every BLINK_CYC cycles, counted from the first error cycle.
- R10: The debug port returns the selected register while halted or errored, and reads zero while the program runs.
- R11: Reset returns an errored sequencer to fetching at address 0 with the error output cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PC_W | Program memory address (program counter) |
| imem_data | input | 16 | Program memory word at imem_addr |
| fpu_start_add | output | 1 | One-cycle start pulse for add |
| fpu_start_sub | output | 1 | One-cycle start pulse for subtract |
| fpu_start_mul | output | 1 | One-cycle start pulse for multiply |
| fpu_start_div | output | 1 | One-cycle start pulse for divide |
| fpu_op_a | output | 32 | First operand |
| fpu_op_b | output | 32 | Second operand |
| fpu_result | input | 32 | Arithmetic result, valid with fpu_done |
| fpu_done | input | 1 | Arithmetic unit finished |
| fpu_exc | input | 1 | Arithmetic exception, valid with fpu_done |
| halted | output | 1 | Program reached its end word |
| err | output | 1 | Sequencer stopped on an error |
| err_led | output | 1 | Blinking error indicator |
| dbg_addr | input | 3 | Debug register select |
| dbg_data | output | 32 | Debug register contents |

## Verification
The bench gives each operation a different unit latency. A sequencer that sampled done at a fixed time, or that restarted fetch at the wrong offset after done, would put its start pulses in the wrong cycles. Programs that read and write the same register in one instruction catch a result written back before the operands were latched. A move checks that the constant halves are not swapped and that the counter skips both of them. The error runs check that a faulting result does not reach its destination, that a malformed word raises an error instead of a start, and that the indicator phase counts from the first error cycle. A design that dropped any of these would give wrong registers on debug readback or a wrong output in some cycle.

// File: rtl/fpcalc_pkg.sv
package fpcalc_pkg;
  localparam int INSTR_W = 16;
  localparam int DATA_W  = 32;
  localparam int RADDR_W = 3;
  localparam int N_ARITH = 4;

  localparam logic [3:0] OP_HALT = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_DIV  = 4'd4;
  localparam logic [3:0] OP_MOVE = 4'd5;

  typedef enum logic [3:0] {
    ST_FETCH, ST_IMM_HI, ST_IMM_LO, ST_DEC1, ST_DEC2, ST_READ,
    ST_EXEC, ST_WB1, ST_WB2, ST_WRITE, ST_HALT, ST_ERR
  } seq_state_e;
endpackage

// File: rtl/fpcalc_regfile.sv
module fpcalc_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  input  logic [ADDR_W-1:0] raddr_c,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b,
  output logic [DATA_W-1:0] rdata_c
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (waddr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[i] <= '0;
      else if (ent_en) mem_q[i] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
  assign rdata_c = mem_q[raddr_c];
endmodule

// File: rtl/fpcalc_blink.sv
module fpcalc_blink #(
  parameter int CYC = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic led
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          led_q, led_d;

  always_comb begin
    cnt_d = cnt_q;
    led_d = led_q;
    if (!en) begin
      cnt_d = '0;
      led_d = 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      led_d = ~led_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      led_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      led_q <= led_d;
    end
  end

  assign led = led_q;
endmodule

// File: rtl/fpcalc_ctrl.sv
module fpcalc_ctrl
  import fpcalc_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [PC_W-1:0]     imem_addr,
  input  logic [INSTR_W-1:0]  imem_data,
  input  logic                fpu_done,
  input  logic                fpu_exc,
  input  logic [DATA_W-1:0]   fpu_result,
  input  logic [DATA_W-1:0]   rf_rdata_a,
  input  logic [DATA_W-1:0]   rf_rdata_b,
  output logic [RADDR_W-1:0]  rf_raddr_a,
  output logic [RADDR_W-1:0]  rf_raddr_b,
  output logic                rf_we,
  output logic [RADDR_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0]   rf_wdata,
  output logic [DATA_W-1:0]   op_a,
  output logic [DATA_W-1:0]   op_b,
  output logic [N_ARITH-1:0]  start,
  output logic                halted,
  output logic                err
);
  localparam int HALF_W = DATA_W / 2;

  seq_state_e          state_q, state_d;
  logic [PC_W-1:0]     pc_q, pc_d;
  logic [3:0]          op_q;
  logic [RADDR_W-1:0]  dst_q, s1_q, s2_q;
  logic [DATA_W-1:0]   imm_q, res_q, opa_q, opb_q;
  logic [N_ARITH-1:0]  start_q, start_d;
  logic                ir_en, immh_en, imml_en, opnd_en, res_en;
  logic [3:0]          f_op;
  logic                f_arith_ok, f_move_ok;

  assign f_op       = imem_data[15:12];
  assign f_arith_ok = (f_op >= OP_ADD) && (f_op <= OP_DIV) && (imem_data[2:0] == 3'b000);
  assign f_move_ok  = (f_op == OP_MOVE) && (imem_data[8:0] == 9'd0);

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ir_en   = 1'b0;
    immh_en = 1'b0;
    imml_en = 1'b0;
    opnd_en = 1'b0;
    res_en  = 1'b0;
    rf_we   = 1'b0;
    start_d = '0;
    unique case (state_q)
      ST_FETCH: begin
        ir_en = 1'b1;
        if (imem_data == '0) begin
          state_d = ST_HALT;
        end else if (f_move_ok) begin
          state_d = ST_IMM_HI;
          pc_d    = pc_q + PC_W'(1);
        end else if (f_arith_ok) begin
          state_d = ST_DEC1;
          pc_d    = pc_q + PC_W'(1);
        end else begin
          state_d = ST_ERR;
        end
      end
      ST_IMM_HI: begin
        immh_en = 1'b1;
        pc_d    = pc_q + PC_W'(1);
        state_d = ST_IMM_LO;
      end
      ST_IMM_LO: begin
        imml_en = 1'b1;
        pc_d    = pc_q + PC_W'(1);
        state_d = ST_WB1;
      end
      ST_DEC1: state_d = ST_DEC2;
      ST_DEC2: state_d = ST_READ;
      ST_READ: begin
        opnd_en = 1'b1;
        for (int k = 0; k < N_ARITH; k++) start_d[k] = (op_q == 4'(k + 1));
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        if (fpu_exc) begin
          state_d = ST_ERR;
        end else if (fpu_done) begin
          res_en  = 1'b1;
          state_d = ST_WB1;
        end
      end
      ST_WB1: state_d = ST_WB2;
      ST_WB2: state_d = ST_WRITE;
      ST_WRITE: begin
        rf_we   = 1'b1;
        state_d = ST_FETCH;
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      start_q <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      dst_q <= '0;
      s1_q  <= '0;
      s2_q  <= '0;
    end else if (ir_en) begin
      op_q  <= f_op;
      dst_q <= imem_data[11:9];
      s1_q  <= imem_data[8:6];
      s2_q  <= imem_data[5:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q <= '0;
    end else if (immh_en) begin
      imm_q[DATA_W-1:HALF_W] <= imem_data[HALF_W-1:0];
    end else if (imml_en) begin
      imm_q[HALF_W-1:0] <= imem_data[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (opnd_en) begin
      opa_q <= rf_rdata_a;
      opb_q <= rf_rdata_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= fpu_result;
  end

  assign imem_addr  = pc_q;
  assign rf_raddr_a = s1_q;
  assign rf_raddr_b = s2_q;
  assign rf_waddr   = dst_q;
  assign rf_wdata   = (op_q == OP_MOVE) ? imm_q : res_q;
  assign op_a       = opa_q;
  assign op_b       = opb_q;
  assign start      = start_q;
  assign halted     = (state_q == ST_HALT);
  assign err        = (state_q == ST_ERR);
endmodule

// File: rtl/fpcalc_seq.sv
module fpcalc_seq
  import fpcalc_pkg::*;
#(
  parameter int PC_W      = 8,
  parameter int BLINK_CYC = 25_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [PC_W-1:0]   imem_addr,
  input  logic [15:0]       imem_data,
  output logic              fpu_start_add,
  output logic              fpu_start_sub,
  output logic              fpu_start_mul,
  output logic              fpu_start_div,
  output logic [31:0]       fpu_op_a,
  output logic [31:0]       fpu_op_b,
  input  logic [31:0]       fpu_result,
  input  logic              fpu_done,
  input  logic              fpu_exc,
  output logic              halted,
  output logic              err,
  output logic              err_led,
  input  logic [2:0]        dbg_addr,
  output logic [31:0]       dbg_data
);
  logic [RADDR_W-1:0] raddr_a, raddr_b, waddr;
  logic [DATA_W-1:0]  rdata_a, rdata_b, rdata_c, wdata;
  logic               we;
  logic [N_ARITH-1:0] start;

  fpcalc_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_data  (imem_data),
    .fpu_done   (fpu_done),
    .fpu_exc    (fpu_exc),
    .fpu_result (fpu_result),
    .rf_rdata_a (rdata_a),
    .rf_rdata_b (rdata_b),
    .rf_raddr_a (raddr_a),
    .rf_raddr_b (raddr_b),
    .rf_we      (we),
    .rf_waddr   (waddr),
    .rf_wdata   (wdata),
    .op_a       (fpu_op_a),
    .op_b       (fpu_op_b),
    .start      (start),
    .halted     (halted),
    .err        (err)
  );

  fpcalc_regfile #(.DATA_W(DATA_W), .ADDR_W(RADDR_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .waddr   (waddr),
    .wdata   (wdata),
    .raddr_a (raddr_a),
    .raddr_b (raddr_b),
    .raddr_c (dbg_addr),
    .rdata_a (rdata_a),
    .rdata_b (rdata_b),
    .rdata_c (rdata_c)
  );

  fpcalc_blink #(.CYC(BLINK_CYC)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (err),
    .led   (err_led)
  );

  assign fpu_start_add = start[0];
  assign fpu_start_sub = start[1];
  assign fpu_start_mul = start[2];
  assign fpu_start_div = start[3];
  assign dbg_data      = (halted || err) ? rdata_c : '0;
endmodule

// File: rtl/fpcalc_seq_chk.sv
module fpcalc_seq_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      starts,
  input logic            halted,
  input logic            err,
  input logic            fpu_exc,
  input logic [PC_W-1:0] imem_addr,
  input logic [31:0]     dbg_data
);
  // R3
  start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(starts));

  // R3
  start_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (starts != 4'b0) |=> (starts == 4'b0));

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(imem_addr)));

  // R6
  stopped_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted || err) |-> (starts == 4'b0));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R7
  exc_to_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fpu_exc && !halted) |=> err);

  // R10
  dbg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && !err) |-> (dbg_data == 32'd0));
endmodule

bind fpcalc_seq fpcalc_seq_chk #(.PC_W(PC_W)) u_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .starts    ({fpu_start_div, fpu_start_mul, fpu_start_sub, fpu_start_add}),
  .halted    (halted),
  .err       (err),
  .fpu_exc   (fpu_exc),
  .imem_addr (imem_addr),
  .dbg_data  (dbg_data)
);

// File: tb/fpcalc_seq_bench.sv
`timescale 1ns/1ps
module fpcalc_seq_bench;
  localparam int PC_W  = 8;
  localparam int BLINK = 4;
  localparam int TAIL  = 14;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic [PC_W-1:0] imem_addr;
  logic [15:0]     imem_data;
  logic            s_add, s_sub, s_mul, s_div;
  logic [31:0]     op_a, op_b, fpu_result;
  logic            fpu_done, fpu_exc;
  logic            halted, err, err_led;
  logic [2:0]      dbg_addr;
  logic [31:0]     dbg_data;

  logic [15:0] mem [256];
  assign imem_data = mem[imem_addr];

  fpcalc_seq #(.PC_W(PC_W), .BLINK_CYC(BLINK)) u_fpcalc_seq (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .fpu_start_add(s_add), .fpu_start_sub(s_sub), .fpu_start_mul(s_mul),
    .fpu_start_div(s_div), .fpu_op_a(op_a), .fpu_op_b(op_b),
    .fpu_result(fpu_result), .fpu_done(fpu_done), .fpu_exc(fpu_exc),
    .halted(halted), .err(err), .err_led(err_led),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  int exc_at = -1;

  function automatic logic [31:0] fmodel(int op, logic [31:0] a, logic [31:0] b);
    case (op)
      1: return a + b;
      2: return a - b;
      3: return 32'(a[15:0] * b[15:0]);
      default: return a ^ {b[15:0], b[31:16]};
    endcase
  endfunction

  // Behavioural arithmetic unit: latency = opcode + 1 cycles after the start.
  logic        fb_busy, fb_exc;
  int          fb_rem, fb_nstart;
  logic [31:0] fb_res;
  wire  [3:0]  starts = {s_div, s_mul, s_sub, s_add};
  assign fpu_done   = fb_busy && (fb_rem == 1);
  assign fpu_exc    = fpu_done && fb_exc;
  assign fpu_result = fb_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_busy <= 1'b0; fb_rem <= 0; fb_nstart <= 0; fb_exc <= 1'b0; fb_res <= '0;
    end else if (starts != 4'b0) begin
      int op;
      op = s_add ? 1 : s_sub ? 2 : s_mul ? 3 : 4;
      fb_busy   <= 1'b1;
      fb_rem    <= op + 1;
      fb_res    <= fmodel(op, op_a, op_b);
      fb_exc    <= (fb_nstart == exc_at);
      fb_nstart <= fb_nstart + 1;
    end else if (fb_busy) begin
      fb_rem <= fb_rem - 1;
      if (fb_rem == 1) fb_busy <= 1'b0;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  typedef struct {
    logic [3:0]  st;
    logic [31:0] a, b;
    logic        h, e, led, ca;
    logic [7:0]  ad;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mrf [8];

  task automatic push(logic [3:0] st, logic [31:0] a, logic [31:0] b,
                      logic h, logic e, logic led, logic ca, logic [7:0] ad);
    exp_t x;
    x.st = st; x.a = a; x.b = b; x.h = h; x.e = e; x.led = led; x.ca = ca; x.ad = ad;
    q.push_back(x);
  endtask

  task automatic plain(int n);
    for (int k = 0; k < n; k++) push(4'b0, '0, '0, 0, 0, 0, 0, '0);
  endtask

  task automatic err_tail();
    for (int k = 0; k < TAIL; k++) push(4'b0, '0, '0, 0, 1, ((k / BLINK) % 2) == 1, 0, '0);
  endtask

  // Expected cycle stream from the instruction set rules (R2-R9).
  task automatic build();
    int pc = 0;
    int ai = 0;
    q.delete();
    for (int r = 0; r < 8; r++) mrf[r] = '0;
    forever begin
      logic [15:0] w;
      int op;
      w  = mem[pc];
      op = int'(w[15:12]);
      push(4'b0, '0, '0, 0, 0, 0, 1, 8'(pc));
      if (w == 16'h0) begin
        for (int k = 0; k < TAIL; k++) push(4'b0, '0, '0, 1, 0, 0, 1, 8'(pc));
        break;
      end else if (op == 5 && w[8:0] == 9'd0) begin
        push(4'b0, '0, '0, 0, 0, 0, 1, 8'(pc + 1));
        push(4'b0, '0, '0, 0, 0, 0, 1, 8'(pc + 2));
        plain(3);
        mrf[w[11:9]] = {mem[pc + 1], mem[pc + 2]};
        pc += 3;
      end else if (op >= 1 && op <= 4 && w[2:0] == 3'd0) begin
        logic [31:0] a, b;
        a = mrf[w[8:6]];
        b = mrf[w[5:3]];
        plain(3);
        push(4'(1 << (op - 1)), a, b, 0, 0, 0, 0, '0);
        plain(op + 1);
        if (ai == exc_at) begin
          err_tail();
          break;
        end
        plain(3);
        mrf[w[11:9]] = fmodel(op, a, b);
        pc += 1;
        ai += 1;
      end else begin
        err_tail();
        break;
      end
    end
  endtask

  function automatic logic [15:0] ar(int op, int d, int s1, int s2);
    return {4'(op), 3'(d), 3'(s1), 3'(s2), 3'b000};
  endfunction

  task automatic run(string tag);
    rst_n = 1'b0;
    dbg_addr = 3'd3;
    build();
    repeat (3) @(negedge clk);
    // R1 / R11: state under reset
    chk(imem_addr == '0, "R1", "reset address", 32'(imem_addr), 0);
    chk(starts == 4'b0, "R1", "reset starts", 32'(starts), 0);
    chk(!halted && !err && !err_led, "R11", "reset flags",
        {29'd0, halted, err, err_led}, 0);
    rst_n = 1'b1;
    foreach (q[i]) begin
      exp_t x;
      x = q[i];
      chk(starts == x.st, "R3", {tag, " start vector"}, 32'(starts), 32'(x.st));
      if (x.st != 4'b0) begin
        chk(op_a == x.a, "R3", {tag, " operand a"}, op_a, x.a);
        chk(op_b == x.b, "R3", {tag, " operand b"}, op_b, x.b);
      end
      chk(halted == x.h, "R6", {tag, " halted"}, 32'(halted), 32'(x.h));
      chk(err == x.e, (tag == "P3") ? "R8" : "R7", {tag, " error"}, 32'(err), 32'(x.e));
      chk(err_led == x.led, "R9", {tag, " indicator"}, 32'(err_led), 32'(x.led));
      if (x.ca)
        chk(imem_addr == x.ad, "R2", {tag, " fetch address"}, 32'(imem_addr), 32'(x.ad));
      if (!x.h && !x.e)
        chk(dbg_data == '0, "R10", {tag, " debug while running"}, dbg_data, 0);
      @(negedge clk);
    end
    // R5 / R10 / R1: register readback after stop
    for (int r = 0; r < 8; r++) begin
      dbg_addr = 3'(r);
      #1;
      chk(dbg_data == mrf[r], "R5", {tag, " register readback"}, dbg_data, mrf[r]);
    end
    dbg_addr = 3'd3;
  endtask

  initial begin
    rst_n = 1'b0;
    dbg_addr = 3'd0;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;

    // P1: moves and all four operations, then halt (R2-R6, R10)
    mem[0]  = {4'd5, 3'd0, 9'd0}; mem[1]  = 16'h3FC0; mem[2]  = 16'h0000;
    mem[3]  = {4'd5, 3'd1, 9'd0}; mem[4]  = 16'h3FE0; mem[5]  = 16'h1234;
    mem[6]  = ar(2, 2, 0, 1);
    mem[7]  = ar(4, 3, 1, 2);
    mem[8]  = {4'd5, 3'd4, 9'd0}; mem[9]  = 16'h4020; mem[10] = 16'h0001;
    mem[11] = ar(3, 5, 3, 4);
    mem[12] = ar(4, 6, 2, 4);
    mem[13] = ar(1, 7, 5, 6);
    mem[14] = 16'h0;
    exc_at = -1;
    run("P1");

    // P2: same-register operands, then an exception on the third operation (R7, R9)
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[0] = {4'd5, 3'd1, 9'd0}; mem[1] = 16'h0000; mem[2] = 16'h0003;
    mem[3] = {4'd5, 3'd2, 9'd0}; mem[4] = 16'h0000; mem[5] = 16'h0010;
    mem[6] = ar(1, 1, 1, 1);
    mem[7] = ar(3, 2, 1, 2);
    mem[8] = ar(2, 3, 2, 1);
    mem[9] = ar(1, 4, 1, 2);
    exc_at = 2;
    run("P2");

    // P3: malformed words raise the error (R8); reset cleared P2's error (R11)
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[0] = {4'd5, 3'd6, 9'd0}; mem[1] = 16'hABCD; mem[2] = 16'h5678;
    mem[3] = ar(1, 2, 6, 6) | 16'h0001;
    exc_at = -1;
    run("P3");

    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[0] = 16'h7000;
    run("P3");

    summary();
    $finish;
  end
endmodule